// File: doc/BRIEF.md
# Data Space Address Generation Unit

This unit sits between the decode stage of a small 8-bit core and its data storage. For each load or store request it forms a 16-bit effective address in one of five addressing modes, checks it against a 224-entry data space, and steers the access to exactly one of three targets: the 32-entry general register file, the 64-entry I/O register block, or the 128-byte internal SRAM. The storage arrays sit outside the unit. It drives their enables, addresses and write data and collects their read data.

Three 16-bit pointers (X, Y and Z) live in the top six general registers. The unit reads them on dedicated input ports. In the two auto-modify modes it writes the updated pointer back through a pointer write port. Register-file and I/O accesses complete in the cycle they are accepted. An SRAM access is sequenced by a three-state controller (`ST_IDLE`, `ST_SRAM_ADDR`, `ST_SRAM_DATA`) and holds `req_ready` low while it runs.

Controller transitions:
- `ST_IDLE` to `ST_SRAM_ADDR`: a valid, error-free request that targets SRAM is accepted.
- `ST_SRAM_ADDR` to `ST_SRAM_DATA`: unconditional. The SRAM address is presented for reading.
- `ST_SRAM_DATA` to `ST_IDLE`: unconditional. The write, the pointer write-back and the response complete here.
- `ST_IDLE` to `ST_IDLE`: no request, a request to the register file or I/O block, or a request in error.

Top module: `dsagu_top`

## Requirements
- R1: The effective address (EA) picks the target. EA 0x00..0x1F drives `rf_en` with `rf_addr`=EA. EA 0x20..0x5F drives `io_en` with `io_addr`=EA-0x20. EA 0x60..0xDF goes to SRAM with `sram_addr`=EA-0x60. At most one target enable is active in any cycle.
- R2: Mode code 0 (direct) uses `req_addr` as the EA. Every location 0x00..0xDF can be read and written this way.
- R3: Mode code 1 (indirect) uses the selected pointer as the EA and leaves the pointer unchanged. `req_ptr` 0 selects X={R27,R26}, 1 selects Y={R29,R28} and 2 selects Z={R31,R30}. The even register holds the low byte.
- R4: Mode code 2 (displacement) uses the pointer plus the unsigned 6-bit `req_disp` (0..63) as the EA, for Y or Z only. With X it reports an error.
- R5: Mode code 3 (pre-decrement) uses pointer-1 as the EA and writes pointer-1 back to the selected pair.
- R6: Mode code 4 (post-increment) uses the original pointer as the EA and writes pointer+1 back to the pair after the access.
- R7: An EA above 0xDF is an error, and so is `req_ptr`=3 in any non-direct mode. A request in error is answered with `rsp_valid` and `rsp_error` one cycle after acceptance. It enables no target and writes back no pointer.
- R8: A register-file or I/O access is accepted while `req_ready`=1 and stays ready. `rsp_valid` pulses on the next cycle. On a read, `rsp_rdata` carries the value stored before the access.
- R9: After an SRAM request is accepted, `req_ready` is low for exactly two cycles. `rsp_valid` (with the read data on a read) pulses as `req_ready` returns high, three cycles after acceptance. A pointer update for such an access lands on that same edge.
- R10: A register-file write whose EA falls in the pointer pair that the same request updates (modes 3 and 4) is dropped. The pair receives only the pointer write-back value.
- R11: Mode codes 5, 6 and 7 are errors handled as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 2 | Pointer select |
| req_addr | input | 16 | Direct address |
| req_disp | input | 6 | Displacement |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 8 | Store data |
| req_ready | output | 1 | Unit can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_error | output | 1 | Response reports an error |
| rsp_rdata | output | 8 | Load data |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| ptr_we | output | 1 | Pointer write-back strobe |
| ptr_sel | output | 2 | Pointer being written back |
| ptr_wdata | output | 16 | Pointer write-back value |
| rf_en | output | 1 | Register file access |
| rf_we | output | 1 | Register file write |
| rf_addr | output | 5 | Register index |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register read data (combinational) |
| io_en | output | 1 | I/O block access |
| io_we | output | 1 | I/O write |
| io_addr | output | 6 | I/O index |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data (combinational) |
| sram_en | output | 1 | SRAM access |
| sram_we | output | 1 | SRAM write |
| sram_addr | output | 7 | SRAM index |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, registered one cycle after `sram_en` |

## Verification
The properties assume that the pointer inputs change only through this unit's own write-back. They also assume that register-file and I/O read data is combinational, while SRAM read data arrives one cycle after the enable. The bench's storage model is built that way: the pointer ports are wired straight to entries 26..31 of its register array. It keeps a single request in flight by waiting for each response before issuing the next. Requests are swept over every direct address and every displacement, and the auto-modify modes are run at bases on both sides of each region edge and inside the pointer registers themselves.

// File: rtl/dsagu_pkg.sv
package dsagu_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        PS_X    = 2'd0,
        PS_Y    = 2'd1,
        PS_Z    = 2'd2,
        PS_RSVD = 2'd3
    } psel_e;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_RF   = 2'd1,
        RG_IO   = 2'd2,
        RG_SRAM = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SRAM_ADDR = 2'd1,
        ST_SRAM_DATA = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/dsagu_ea.sv
// Effective address, pointer update value and request legality.
module dsagu_ea
    import dsagu_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DISP_W   = 6,
    parameter int TOP_ADDR = 223
) (
    input  logic [2:0]        mode,
    input  logic [1:0]        sel,
    input  logic [AW-1:0]     dir_addr,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     ptr_x,
    input  logic [AW-1:0]     ptr_y,
    input  logic [AW-1:0]     ptr_z,
    output logic [AW-1:0]     ea,
    output logic              ptr_upd,
    output logic [AW-1:0]     ptr_next,
    output logic              bad
);

    logic [AW-1:0] base;
    logic          mode_bad;
    logic          sel_bad;
    logic          range_bad;

    always_comb begin
        unique case (sel)
            PS_X:    base = ptr_x;
            PS_Y:    base = ptr_y;
            PS_Z:    base = ptr_z;
            default: base = '0;
        endcase
    end

    always_comb begin
        ea       = '0;
        ptr_upd  = 1'b0;
        ptr_next = base;
        mode_bad = 1'b0;
        unique case (mode)
            AM_DIRECT: ea = dir_addr;
            AM_IND:    ea = base;
            AM_DISP: begin
                ea       = base + AW'(disp);
                mode_bad = (sel == PS_X);
            end
            AM_PREDEC: begin
                ea       = base - AW'(1);
                ptr_upd  = 1'b1;
                ptr_next = base - AW'(1);
            end
            AM_POSTINC: begin
                ea       = base;
                ptr_upd  = 1'b1;
                ptr_next = base + AW'(1);
            end
            default: mode_bad = 1'b1;
        endcase
    end

    assign sel_bad   = (mode != AM_DIRECT) && (sel == PS_RSVD);
    assign range_bad = (ea > AW'(TOP_ADDR));
    assign bad       = mode_bad | sel_bad | range_bad;

endmodule

// File: rtl/dsagu_region.sv
// Splits the data space into consecutive regions and forms local offsets.
module dsagu_region
    import dsagu_pkg::*;
#(
    parameter int AW         = 16,
    parameter int RF_DEPTH   = 32,
    parameter int IO_DEPTH   = 64,
    parameter int SRAM_DEPTH = 128,
    localparam int RF_AW     = $clog2(RF_DEPTH),
    localparam int IO_AW     = $clog2(IO_DEPTH),
    localparam int SR_AW     = $clog2(SRAM_DEPTH)
) (
    input  logic [AW-1:0]    ea,
    output region_e          region,
    output logic [RF_AW-1:0] rf_off,
    output logic [IO_AW-1:0] io_off,
    output logic [SR_AW-1:0] sram_off
);

    localparam int NREG = 3;
    localparam int LIMS [NREG+1] = '{0, RF_DEPTH, RF_DEPTH + IO_DEPTH,
                                     RF_DEPTH + IO_DEPTH + SRAM_DEPTH};

    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign hit[g] = (ea >= AW'(LIMS[g])) && (ea < AW'(LIMS[g+1]));
    end

    always_comb begin
        region = RG_NONE;
        if (hit[0]) region = RG_RF;
        if (hit[1]) region = RG_IO;
        if (hit[2]) region = RG_SRAM;
    end

    assign rf_off   = ea[RF_AW-1:0];
    assign io_off   = IO_AW'(ea - AW'(LIMS[1]));
    assign sram_off = SR_AW'(ea - AW'(LIMS[2]));

endmodule

// File: rtl/dsagu_ctrl.sv
// Access sequencer: one-cycle register/I-O path, two-cycle SRAM path.
module dsagu_ctrl
    import dsagu_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int RF_AW = 5,
    parameter int IO_AW = 6,
    parameter int SR_AW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [DW-1:0]    req_wdata,
    input  logic [1:0]       req_ptr,
    input  logic             bad,
    input  region_e          region,
    input  logic [RF_AW-1:0] rf_off,
    input  logic [IO_AW-1:0] io_off,
    input  logic [SR_AW-1:0] sram_off,
    input  logic             ptr_upd,
    input  logic [AW-1:0]    ptr_next,
    input  logic             ptr_hit,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic             rsp_error,
    output logic [DW-1:0]    rsp_rdata,
    output logic             ptr_we,
    output logic [1:0]       ptr_sel,
    output logic [AW-1:0]    ptr_wdata,
    output logic             rf_en,
    output logic             rf_we,
    output logic [RF_AW-1:0] rf_addr,
    output logic [DW-1:0]    rf_wdata,
    input  logic [DW-1:0]    rf_rdata,
    output logic             io_en,
    output logic             io_we,
    output logic [IO_AW-1:0] io_addr,
    output logic [DW-1:0]    io_wdata,
    input  logic [DW-1:0]    io_rdata,
    output logic             sram_en,
    output logic             sram_we,
    output logic [SR_AW-1:0] sram_addr,
    output logic [DW-1:0]    sram_wdata,
    input  logic [DW-1:0]    sram_rdata
);

    ctl_state_e       state;
    ctl_state_e       nxt;
    logic             accept;
    logic [SR_AW-1:0] l_addr;
    logic             l_we;
    logic [DW-1:0]    l_wdata;
    logic             l_upd;
    logic [1:0]       l_sel;
    logic [AW-1:0]    l_next;

    assign accept = (state == ST_IDLE) && req_valid && !bad;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Held SRAM request and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_addr    <= '0;
            l_we      <= 1'b0;
            l_wdata   <= '0;
            l_upd     <= 1'b0;
            l_sel     <= '0;
            l_next    <= '0;
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (bad) begin
                            rsp_valid <= 1'b1;
                            rsp_error <= 1'b1;
                            rsp_rdata <= '0;
                        end else if (region == RG_SRAM) begin
                            l_addr  <= sram_off;
                            l_we    <= req_we;
                            l_wdata <= req_wdata;
                            l_upd   <= ptr_upd;
                            l_sel   <= req_ptr;
                            l_next  <= ptr_next;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_error <= 1'b0;
                            rsp_rdata <= (region == RG_IO) ? io_rdata : rf_rdata;
                        end
                    end
                end
                ST_SRAM_ADDR: begin
                end
                ST_SRAM_DATA: begin
                    rsp_valid <= 1'b1;
                    rsp_error <= 1'b0;
                    rsp_rdata <= l_we ? '0 : sram_rdata;
                end
                default: begin
                end
            endcase
        end
    end

    // Next state and outputs
    always_comb begin
        nxt        = state;
        req_ready  = 1'b0;
        rf_en      = 1'b0;
        rf_we      = 1'b0;
        rf_addr    = rf_off;
        rf_wdata   = req_wdata;
        io_en      = 1'b0;
        io_we      = 1'b0;
        io_addr    = io_off;
        io_wdata   = req_wdata;
        sram_en    = 1'b0;
        sram_we    = 1'b0;
        sram_addr  = l_addr;
        sram_wdata = l_wdata;
        ptr_we     = 1'b0;
        ptr_sel    = req_ptr;
        ptr_wdata  = ptr_next;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (accept) begin
                    unique case (region)
                        RG_RF: begin
                            rf_en  = 1'b1;
                            rf_we  = req_we && !ptr_hit;
                            ptr_we = ptr_upd;
                        end
                        RG_IO: begin
                            io_en  = 1'b1;
                            io_we  = req_we;
                            ptr_we = ptr_upd;
                        end
                        RG_SRAM: nxt = ST_SRAM_ADDR;
                        default: begin
                        end
                    endcase
                end
            end
            ST_SRAM_ADDR: begin
                sram_en = 1'b1;
                nxt     = ST_SRAM_DATA;
            end
            ST_SRAM_DATA: begin
                sram_en   = l_we;
                sram_we   = l_we;
                ptr_we    = l_upd;
                ptr_sel   = l_sel;
                ptr_wdata = l_next;
                nxt       = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dsagu_top.sv
module dsagu_top
    import dsagu_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int DISP_W     = 6,
    parameter int RF_DEPTH   = 32,
    parameter int IO_DEPTH   = 64,
    parameter int SRAM_DEPTH = 128,
    localparam int RF_AW     = $clog2(RF_DEPTH),
    localparam int IO_AW     = $clog2(IO_DEPTH),
    localparam int SR_AW     = $clog2(SRAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic [1:0]        req_ptr,
    input  logic [AW-1:0]     req_addr,
    input  logic [DISP_W-1:0] req_disp,
    input  logic              req_we,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [DW-1:0]     rsp_rdata,
    input  logic [AW-1:0]     ptr_x,
    input  logic [AW-1:0]     ptr_y,
    input  logic [AW-1:0]     ptr_z,
    output logic              ptr_we,
    output logic [1:0]        ptr_sel,
    output logic [AW-1:0]     ptr_wdata,
    output logic              rf_en,
    output logic              rf_we,
    output logic [RF_AW-1:0]  rf_addr,
    output logic [DW-1:0]     rf_wdata,
    input  logic [DW-1:0]     rf_rdata,
    output logic              io_en,
    output logic              io_we,
    output logic [IO_AW-1:0]  io_addr,
    output logic [DW-1:0]     io_wdata,
    input  logic [DW-1:0]     io_rdata,
    output logic              sram_en,
    output logic              sram_we,
    output logic [SR_AW-1:0]  sram_addr,
    output logic [DW-1:0]     sram_wdata,
    input  logic [DW-1:0]     sram_rdata
);

    localparam int TOP_ADDR = RF_DEPTH + IO_DEPTH + SRAM_DEPTH - 1;
    localparam int PTR_BASE = RF_DEPTH - 6;     // three pairs at the top
    localparam int PTR_PAIR = PTR_BASE / 2;     // pair index of X
    localparam int PW       = RF_AW - 1;

    logic [AW-1:0]    ea;
    logic             ptr_upd;
    logic [AW-1:0]    ptr_next;
    logic             bad;
    region_e          region;
    logic [RF_AW-1:0] rf_off;
    logic [IO_AW-1:0] io_off;
    logic [SR_AW-1:0] sram_off;
    logic             ptr_hit;

    dsagu_ea #(.AW(AW), .DISP_W(DISP_W), .TOP_ADDR(TOP_ADDR)) u_ea (
        .mode     (req_mode),
        .sel      (req_ptr),
        .dir_addr (req_addr),
        .disp     (req_disp),
        .ptr_x    (ptr_x),
        .ptr_y    (ptr_y),
        .ptr_z    (ptr_z),
        .ea       (ea),
        .ptr_upd  (ptr_upd),
        .ptr_next (ptr_next),
        .bad      (bad)
    );

    dsagu_region #(.AW(AW), .RF_DEPTH(RF_DEPTH), .IO_DEPTH(IO_DEPTH),
                   .SRAM_DEPTH(SRAM_DEPTH)) u_region (
        .ea       (ea),
        .region   (region),
        .rf_off   (rf_off),
        .io_off   (io_off),
        .sram_off (sram_off)
    );

    // Data write into the pair being updated loses to the write-back
    assign ptr_hit = ptr_upd && (region == RG_RF)
                     && (rf_off[RF_AW-1:1] == PW'(PTR_PAIR + int'(req_ptr)));

    dsagu_ctrl #(.AW(AW), .DW(DW), .RF_AW(RF_AW), .IO_AW(IO_AW),
                 .SR_AW(SR_AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_wdata  (req_wdata),
        .req_ptr    (req_ptr),
        .bad        (bad),
        .region     (region),
        .rf_off     (rf_off),
        .io_off     (io_off),
        .sram_off   (sram_off),
        .ptr_upd    (ptr_upd),
        .ptr_next   (ptr_next),
        .ptr_hit    (ptr_hit),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_error  (rsp_error),
        .rsp_rdata  (rsp_rdata),
        .ptr_we     (ptr_we),
        .ptr_sel    (ptr_sel),
        .ptr_wdata  (ptr_wdata),
        .rf_en      (rf_en),
        .rf_we      (rf_we),
        .rf_addr    (rf_addr),
        .rf_wdata   (rf_wdata),
        .rf_rdata   (rf_rdata),
        .io_en      (io_en),
        .io_we      (io_we),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata)
    );

endmodule

// File: rtl/dsagu_chk.sv
module dsagu_chk #(
    parameter int RF_AW    = 5,
    parameter int PTR_PAIR = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_mode,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_error,
    input logic             ptr_we,
    input logic [1:0]       ptr_sel,
    input logic             rf_en,
    input logic             rf_we,
    input logic [RF_AW-1:0] rf_addr,
    input logic             io_en,
    input logic             sram_en
);

    localparam int PW = RF_AW - 1;

    a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_en, io_en, sram_en}));

    a_r7_error_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |-> $past(!rf_en && !io_en && !sram_en && !ptr_we));

    a_r8_fast_response: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en || io_en) |=> (rsp_valid && !rsp_error));

    a_r9_stall_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |=> !req_ready);

    a_r9_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |=> req_ready);

    a_r9_resp_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (rsp_valid && !rsp_error));

    a_r10_ptr_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && rf_en && rf_we) |-> (rf_addr[RF_AW-1:1] != PW'(PTR_PAIR + int'(ptr_sel))));

    a_r11_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mode > 3'd4)) |=> (rsp_valid && rsp_error));

endmodule

bind dsagu_top dsagu_chk #(.RF_AW(RF_AW), .PTR_PAIR(PTR_PAIR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_error (rsp_error),
    .ptr_we    (ptr_we),
    .ptr_sel   (ptr_sel),
    .rf_en     (rf_en),
    .rf_we     (rf_we),
    .rf_addr   (rf_addr),
    .io_en     (io_en),
    .sram_en   (sram_en)
);

// File: tb/test_dsagu_top.sv
`timescale 1ns/1ps
module test_dsagu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_ptr = '0;
    logic [15:0] req_addr = '0;
    logic [5:0]  req_disp = '0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_error;
    logic [7:0]  rsp_rdata;
    logic [15:0] ptr_x, ptr_y, ptr_z, ptr_wdata;
    logic        ptr_we;
    logic [1:0]  ptr_sel;
    logic        rf_en, rf_we, io_en, io_we, sram_en, sram_we;
    logic [4:0]  rf_addr;
    logic [5:0]  io_addr;
    logic [6:0]  sram_addr;
    logic [7:0]  rf_wdata, io_wdata, sram_wdata, rf_rdata, io_rdata, sram_rdata;

    // storage model
    logic [7:0]  rf_m [32];
    logic [7:0]  io_m [64];
    logic [7:0]  sr_m [128];
    logic [7:0]  sr_q;
    logic        init_req = 1'b1;
    logic [7:0]  seed = 8'h11;
    logic        setp_en = 1'b0;
    logic [1:0]  setp_sel = '0;
    logic [15:0] setp_val = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dsagu_top i_dsagu_top (.*);

    assign ptr_x      = {rf_m[27], rf_m[26]};
    assign ptr_y      = {rf_m[29], rf_m[28]};
    assign ptr_z      = {rf_m[31], rf_m[30]};
    assign rf_rdata   = rf_m[rf_addr];
    assign io_rdata   = io_m[io_addr];
    assign sram_rdata = sr_q;

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < 32; i++)  rf_m[i] <= 8'(i * 13) + seed;
            for (int i = 0; i < 64; i++)  io_m[i] <= 8'(i * 29) + seed + 8'd1;
            for (int i = 0; i < 128; i++) sr_m[i] <= 8'(i * 7) ^ seed;
        end
        if (setp_en) begin
            rf_m[26 + 2 * int'(setp_sel)] <= setp_val[7:0];
            rf_m[27 + 2 * int'(setp_sel)] <= setp_val[15:8];
        end
        // pointer first, data after: an unsuppressed data write would win
        if (ptr_we && ptr_sel != 2'd3) begin
            rf_m[26 + 2 * int'(ptr_sel)] <= ptr_wdata[7:0];
            rf_m[27 + 2 * int'(ptr_sel)] <= ptr_wdata[15:8];
        end
        if (rf_en && rf_we) rf_m[rf_addr] <= rf_wdata;
        if (io_en && io_we) io_m[io_addr] <= io_wdata;
        if (sram_en) sr_q <= sr_m[sram_addr];
        if (sram_en && sram_we) sr_m[sram_addr] <= sram_wdata;
    end

    function automatic logic [15:0] get_ptr(input logic [1:0] s);
        case (s)
            2'd0:    return {rf_m[27], rf_m[26]};
            2'd1:    return {rf_m[29], rf_m[28]};
            2'd2:    return {rf_m[31], rf_m[30]};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        if (a < 16'd32)      return rf_m[a[4:0]];
        else if (a < 16'd96) return io_m[6'(a - 16'd32)];
        else                 return sr_m[7'(a - 16'd96)];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_init(input logic [7:0] s);
        @(negedge clk);
        seed = s;
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
    endtask

    task automatic set_ptr(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        setp_en = 1'b1; setp_sel = s; setp_val = v;
        @(negedge clk);
        setp_en = 1'b0;
    endtask

    task automatic op(input logic [2:0] m, input logic [1:0] s, input logic [15:0] a,
                      input logic [5:0] d, input bit w, input logic [7:0] wd,
                      input string tag);
        logic [15:0] p, ea, nptr, eptr;
        logic [7:0]  old, exp_byte;
        bit err, upd, inpair, ready_low;
        int lat, exp_lat;
        p = get_ptr(s);
        upd = 1'b0; nptr = p; err = 1'b0;
        case (m)
            3'd0: ea = a;
            3'd1: ea = p;
            3'd2: begin ea = p + 16'(d); err = (s == 2'd0); end
            3'd3: begin ea = p - 16'd1; upd = 1'b1; nptr = p - 16'd1; end
            3'd4: begin ea = p; upd = 1'b1; nptr = p + 16'd1; end
            default: begin ea = 16'h0000; err = 1'b1; end
        endcase
        if (m != 3'd0 && s == 2'd3) err = 1'b1;
        if (ea > 16'h00DF) err = 1'b1;
        old = (ea <= 16'h00DF) ? mem_rd(ea) : 8'h00;
        inpair = (s != 2'd3) && (ea[15:1] == 15'(13 + int'(s)));
        eptr = p;
        if (!err && upd) eptr = nptr;
        else if (!err && w && inpair) begin
            if (ea[0]) eptr[15:8] = wd; else eptr[7:0] = wd;
        end
        exp_lat = (!err && ea >= 16'h0060) ? 3 : 1;

        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_ptr = s; req_addr = a;
        req_disp = d; req_we = w; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        ready_low = 1'b1;
        while (!rsp_valid && lat < 8) begin
            if (req_ready) ready_low = 1'b0;
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, (exp_lat == 3) ? "R9" : "R8", "latency", lat, exp_lat);
        if (exp_lat == 3)
            chk(ready_low && req_ready, "R9", "ready low for two cycles", int'(ready_low), 1);
        chk(rsp_error == err, tag, "error flag", int'(rsp_error), int'(err));
        if (!err && !w)
            chk(rsp_rdata == old, tag, "read data", int'(rsp_rdata), int'(old));
        if (!err && w) begin
            exp_byte = wd;
            if (upd && inpair) exp_byte = ea[0] ? nptr[15:8] : nptr[7:0];
            chk(mem_rd(ea) == exp_byte, (upd && inpair) ? "R10" : tag,
                "stored byte", int'(mem_rd(ea)), int'(exp_byte));
        end
        if (err && w && ea <= 16'h00DF)
            chk(mem_rd(ea) == old, "R7", "location untouched", int'(mem_rd(ea)), int'(old));
        if (s != 2'd3)
            chk(get_ptr(s) == eptr, (err ? "R7" : tag), "pointer after", int'(get_ptr(s)), int'(eptr));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] bases [16];
        bases = '{16'h0000, 16'h0001, 16'h001A, 16'h001B, 16'h001C, 16'h001D,
                  16'h001E, 16'h001F, 16'h0020, 16'h0021, 16'h005F, 16'h0060,
                  16'h0061, 16'h00DF, 16'h00E0, 16'hFFFF};
        repeat (4) @(negedge clk);
        init_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R8: idle and ready, nothing enabled)
        chk(req_ready && !rsp_valid && !rf_en && !io_en && !sram_en && !ptr_we,
            "R8", "reset state", int'({req_ready, rsp_valid, rf_en, io_en, sram_en, ptr_we}), 32);

        // R1 / R2: direct read of every location, then out of range (R7)
        for (int i = 0; i < 224; i++) op(3'd0, 2'd0, 16'(i), 6'd0, 1'b0, 8'h00, "R1");
        op(3'd0, 2'd0, 16'h00E0, 6'd0, 1'b0, 8'h00, "R7");
        op(3'd0, 2'd0, 16'h00FF, 6'd0, 1'b1, 8'h3C, "R7");
        op(3'd0, 2'd0, 16'h0100, 6'd0, 1'b0, 8'h00, "R7");
        op(3'd0, 2'd0, 16'hFFFF, 6'd0, 1'b1, 8'h3C, "R7");

        // R2: direct write of every location
        for (int i = 0; i < 224; i++) op(3'd0, 2'd0, 16'(i), 6'd0, 1'b1, 8'(i) ^ 8'hA5, "R2");
        do_init(8'h42);

        // R3: indirect through each pointer
        for (int s = 0; s < 3; s++)
            for (int e = 0; e < 232; e += 5) begin
                set_ptr(2'(s), 16'(e));
                op(3'd1, 2'(s), 16'h0000, 6'd0, e[0], 8'(e * 3 + 1), "R3");
            end

        // R4: displacement with Y and Z, every offset; X refused
        for (int s = 1; s < 3; s++)
            for (int b = 0; b < 4; b++)
                for (int d = 0; d < 64; d++) begin
                    set_ptr(2'(s), 16'(b * 56 + s));
                    op(3'd2, 2'(s), 16'h0000, 6'(d), d[0], 8'(d + b), "R4");
                end
        set_ptr(2'd0, 16'h0040);
        op(3'd2, 2'd0, 16'h0000, 6'd3, 1'b0, 8'h00, "R4");
        op(3'd2, 2'd0, 16'h0000, 6'd3, 1'b1, 8'h77, "R4");

        // R5 / R6 / R10: auto-modify across region edges and the pointer pairs
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 16; k++)
                for (int w = 0; w < 2; w++) begin
                    set_ptr(2'(s), bases[k]);
                    op(3'd3, 2'(s), 16'h0000, 6'd0, w[0], 8'(k * 17 + 5), "R5");
                    set_ptr(2'(s), bases[k]);
                    op(3'd4, 2'(s), 16'h0000, 6'd0, w[0], 8'(k * 11 + 9), "R6");
                end

        // R11: undefined mode codes; reserved pointer select (R7)
        for (int m = 5; m < 8; m++)
            for (int s = 0; s < 4; s++) op(3'(m), 2'(s), 16'h0010, 6'd1, s[0], 8'h5A, "R11");
        for (int m = 1; m < 5; m++) op(3'(m), 2'd3, 16'h0000, 6'd0, 1'b0, 8'h00, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule